// File: doc/BRIEF.md
# Indirect-Access Host Register Bridge

This block lets a host with an 8-bit parallel bus and a 3-bit external address reach a 20-bit-wide, 10-bit-addressed internal register space. The host first sets up a pointer. A control register holds the two upper pointer bits and a six-bit channel-select field. A second register holds the low pointer byte. Three staging registers then carry the wide word to or from the internal space.

Only an access to staging register 0 moves data across the internal bus. A write there launches an internal write of the full staged word. A read there fetches the word into all three staging registers and returns the low byte. The remaining bytes are then read from staging registers 1 and 2 with no further internal traffic.

A static mode pin chooses the host handshake. In strobe-pair mode, separate read and write strobes are used and a ready line is held low while an access is in progress. In data-strobe mode, a single data strobe is paired with a read/write direction line. In that mode an acknowledge line goes low once the access is done and stays low until the strobe is removed. The host strobes are synchronized to the core clock and edge-detected. The internal side is a simple master: a level request with address, channel, direction and write word, answered by a one-cycle done pulse after any number of cycles.

Top module: `hostport_bridge`

## Requirements
- R1: After reset, `host_rdy` is 1, `mem_req` is 0 and `dout` is 0.
- R2: The internal address is {pointer-control[1:0], pointer-low[7:0]} and the channel is pointer-control[7:2]. Pointer-low sits at external address 6 and pointer-control at address 7. Both may be written in either order and both read back unchanged.
- R3: Writing external addresses 1 or 2 (staging 1 or 2), 6 or 7 issues no internal access. Writing address 0 issues exactly one internal write of {stage2[3:0], stage1, written byte}.
- R4: Reading address 0 issues exactly one internal read and returns bits 7:0 of the result. Later reads of addresses 1 and 2 return bits 15:8 and {0000, bits 19:16} without an internal access.
- R5: Staging register 2 keeps only bits 3:0 of a written byte, and it reads back with bits 7:4 as zero.
- R6: Addresses 3, 4 and 5 are reserved. A write to them changes nothing, and a read from them returns 0.
- R7: With chip select held low, each separate strobe pulse is exactly one access.
- R8: In strobe-pair mode (`bus_mode`=0), `host_rdy` goes low for every access and stays low until the internal done pulse has been received.
- R9: In data-strobe mode (`bus_mode`=1), `host_rdy` stays high while the internal request is pending. It goes low after completion, stays low while the data strobe is held, and returns high after the strobe is removed.
- R10: Once raised, `mem_req` stays high, with address, channel, direction and write word stable, until `mem_done`.
- R11: Strobes given while `cs_n` is high cause no access and no handshake activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_mode | input | 1 | 0 = read/write strobe pair, 1 = data strobe with direction line |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe (mode 0) or data strobe (mode 1), active low |
| wr_n | input | 1 | Write strobe (mode 0) or direction, 1 = read (mode 1) |
| addr | input | 3 | External register address |
| din | input | 8 | Host write data |
| dout | output | 8 | Host read data |
| host_rdy | output | 1 | Ready (mode 0) or acknowledge (mode 1), active low |
| mem_req | output | 1 | Internal access request |
| mem_we | output | 1 | Internal access direction, 1 = write |
| mem_addr | output | 10 | Internal address |
| mem_chan | output | 6 | Internal channel select |
| mem_wdata | output | 20 | Internal write word |
| mem_rdata | input | 20 | Internal read word, valid with `mem_done` |
| mem_done | input | 1 | One-cycle completion pulse |

## Verification
The properties assume that `bus_mode` changes only while the port is idle. They assume that the address and write byte are steady for the whole time a strobe is low. They also assume that `mem_done` comes only while a request is pending. The bench keeps within these assumptions: it switches mode only between accesses, sets the address and data on the same edge as the strobe and holds them until release, and it models the internal side as a responder that pulses done exactly once per request after a fixed latency. It also waits for the handshake to return to idle, plus a few cycles, before the next strobe. This lets the synchronized strobe drop and keeps each pulse a distinct edge.

// File: rtl/hpb_pkg.sv
package hpb_pkg;
    localparam int DATA_W  = 8;
    localparam int XADDR_W = 3;
    localparam int IADDR_W = 10;
    localparam int WORD_W  = 20;
    localparam int HI_W    = IADDR_W - DATA_W;
    localparam int CHAN_W  = DATA_W - HI_W;
    localparam int TOP_W   = WORD_W - 2 * DATA_W;

    localparam logic [XADDR_W-1:0] XA_STG0 = 3'd0;
    localparam logic [XADDR_W-1:0] XA_STG1 = 3'd1;
    localparam logic [XADDR_W-1:0] XA_STG2 = 3'd2;
    localparam logic [XADDR_W-1:0] XA_PLO  = 3'd6;
    localparam logic [XADDR_W-1:0] XA_PCTL = 3'd7;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_MEM,
        ST_FIN,
        ST_HOLD
    } acc_state_e;

    typedef struct packed {
        logic [CHAN_W-1:0] chan;
        logic [HI_W-1:0]   hi;
    } ptr_ctl_t;

    function automatic logic strobe_active(input logic mode, input logic cs_n,
                                           input logic rd_n, input logic wr_n);
        return !cs_n && (mode ? !rd_n : (!rd_n || !wr_n));
    endfunction

    function automatic logic access_is_read(input logic mode, input logic rd_n,
                                            input logic wr_n);
        return mode ? wr_n : !rd_n;
    endfunction
endpackage

// File: rtl/hpb_bus_sync.sv
module hpb_bus_sync
    import hpb_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic mode,
    input  logic cs_n,
    input  logic rd_n,
    input  logic wr_n,
    output logic act,
    output logic is_rd,
    output logic start
);
    logic [STAGES-1:0] cs_q, rd_q, wr_q;
    logic act_d;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) begin
                    cs_q <= '1; rd_q <= '1; wr_q <= '1;
                end else begin
                    cs_q <= cs_n; rd_q <= rd_n; wr_q <= wr_n;
                end
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) begin
                    cs_q <= '1; rd_q <= '1; wr_q <= '1;
                end else begin
                    cs_q <= {cs_q[STAGES-2:0], cs_n};
                    rd_q <= {rd_q[STAGES-2:0], rd_n};
                    wr_q <= {wr_q[STAGES-2:0], wr_n};
                end
            end
        end
    endgenerate

    assign act   = strobe_active(mode, cs_q[STAGES-1], rd_q[STAGES-1], wr_q[STAGES-1]);
    assign is_rd = access_is_read(mode, rd_q[STAGES-1], wr_q[STAGES-1]);

    always_ff @(posedge clk) begin
        if (rst) act_d <= 1'b0;
        else     act_d <= act;
    end

    assign start = act && !act_d;
endmodule

// File: rtl/hpb_regbank.sv
module hpb_regbank
    import hpb_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [XADDR_W-1:0] addr,
    input  logic [DATA_W-1:0]  din,
    input  logic               ld_mem,
    input  logic [WORD_W-1:0]  mem_rdata,
    output logic [DATA_W-1:0]  dout,
    output logic [WORD_W-1:0]  stage_word,
    output ptr_ctl_t           ptr_ctl,
    output logic [DATA_W-1:0]  ptr_lo
);
    logic [DATA_W-1:0] stg0, stg1;
    logic [TOP_W-1:0]  stg2;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg0    <= '0;
            stg1    <= '0;
            stg2    <= '0;
            ptr_lo  <= '0;
            ptr_ctl <= '0;
            dout    <= '0;
        end else if (ld_mem) begin
            stg0 <= mem_rdata[DATA_W-1:0];
            stg1 <= mem_rdata[2*DATA_W-1:DATA_W];
            stg2 <= mem_rdata[WORD_W-1:2*DATA_W];
            dout <= mem_rdata[DATA_W-1:0];
        end else if (reg_wr) begin
            case (addr)
                XA_STG0: stg0    <= din;
                XA_STG1: stg1    <= din;
                XA_STG2: stg2    <= din[TOP_W-1:0];
                XA_PLO:  ptr_lo  <= din;
                XA_PCTL: ptr_ctl <= ptr_ctl_t'(din);
                default: ;
            endcase
        end else if (reg_rd) begin
            case (addr)
                XA_STG0: ;
                XA_STG1: dout <= stg1;
                XA_STG2: dout <= {{(DATA_W-TOP_W){1'b0}}, stg2};
                XA_PLO:  dout <= ptr_lo;
                XA_PCTL: dout <= DATA_W'(ptr_ctl);
                default: dout <= '0;
            endcase
        end
    end

    assign stage_word = {stg2, stg1, stg0};
endmodule

// File: rtl/hpb_access_ctrl.sv
module hpb_access_ctrl
    import hpb_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               mode,
    input  logic               act,
    input  logic               is_rd,
    input  logic               start,
    input  logic [XADDR_W-1:0] addr,
    input  logic               mem_done,
    output logic               reg_wr,
    output logic               reg_rd,
    output logic               ld_mem,
    output logic               mem_req,
    output logic               mem_we,
    output logic               host_rdy
);
    acc_state_e state, nxt;
    logic       accept, launch;

    assign accept = (state == ST_IDLE) && start;
    assign launch = accept && (addr == XA_STG0);
    assign reg_wr = accept && !is_rd;
    assign reg_rd = accept && is_rd;

    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE: if (accept) nxt = launch ? ST_MEM : ST_FIN;
            ST_MEM:  if (mem_done) nxt = ST_FIN;
            ST_FIN:  nxt = ST_HOLD;
            ST_HOLD: if (!act) nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            mem_we <= 1'b0;
        end else begin
            state <= nxt;
            if (launch) mem_we <= !is_rd;
        end
    end

    assign mem_req  = (state == ST_MEM);
    assign ld_mem   = (state == ST_MEM) && mem_done && !mem_we;
    assign host_rdy = mode ? !((state == ST_FIN) || (state == ST_HOLD))
                           : !((state == ST_MEM) || (state == ST_FIN));
endmodule

// File: rtl/hostport_bridge.sv
module hostport_bridge
    import hpb_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_mode,
    input  logic               cs_n,
    input  logic               rd_n,
    input  logic               wr_n,
    input  logic [XADDR_W-1:0] addr,
    input  logic [DATA_W-1:0]  din,
    output logic [DATA_W-1:0]  dout,
    output logic               host_rdy,
    output logic               mem_req,
    output logic               mem_we,
    output logic [IADDR_W-1:0] mem_addr,
    output logic [CHAN_W-1:0]  mem_chan,
    output logic [WORD_W-1:0]  mem_wdata,
    input  logic [WORD_W-1:0]  mem_rdata,
    input  logic               mem_done
);
    logic     act, is_rd, start;
    logic     reg_wr, reg_rd, ld_mem;
    ptr_ctl_t ptr_ctl;
    logic [DATA_W-1:0] ptr_lo;

    hpb_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .mode(bus_mode), .cs_n(cs_n), .rd_n(rd_n),
        .wr_n(wr_n), .act(act), .is_rd(is_rd), .start(start)
    );

    hpb_access_ctrl u_ctrl (
        .clk(clk), .rst(rst), .mode(bus_mode), .act(act), .is_rd(is_rd),
        .start(start), .addr(addr), .mem_done(mem_done), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .ld_mem(ld_mem), .mem_req(mem_req), .mem_we(mem_we),
        .host_rdy(host_rdy)
    );

    hpb_regbank u_regs (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .addr(addr),
        .din(din), .ld_mem(ld_mem), .mem_rdata(mem_rdata), .dout(dout),
        .stage_word(mem_wdata), .ptr_ctl(ptr_ctl), .ptr_lo(ptr_lo)
    );

    assign mem_addr = {ptr_ctl.hi, ptr_lo};
    assign mem_chan = ptr_ctl.chan;
endmodule

// File: rtl/hpb_checker.sv
module hpb_checker
    import hpb_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               bus_mode,
    input logic               cs_n,
    input logic               rd_n,
    input logic               host_rdy,
    input logic               mem_req,
    input logic               mem_we,
    input logic [IADDR_W-1:0] mem_addr,
    input logic [CHAN_W-1:0]  mem_chan,
    input logic [WORD_W-1:0]  mem_wdata,
    input logic               mem_done
);
    assert_req_held_R10: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_done |=> mem_req);

    assert_req_stable_R10: assert property (@(posedge clk) disable iff (rst)
        mem_req && $past(mem_req) |-> $stable(mem_addr) && $stable(mem_chan)
                                    && $stable(mem_we) && $stable(mem_wdata));

    assert_pair_busy_R8: assert property (@(posedge clk) disable iff (rst)
        !bus_mode && mem_req |-> !host_rdy);

    assert_ack_late_R9: assert property (@(posedge clk) disable iff (rst)
        bus_mode && mem_req |-> host_rdy);

    assert_ack_hold_R9: assert property (@(posedge clk) disable iff (rst)
        bus_mode && !host_rdy && !cs_n && !rd_n |=> !host_rdy);
endmodule

bind hostport_bridge hpb_checker u_chk (
    .clk(clk), .rst(rst), .bus_mode(bus_mode), .cs_n(cs_n), .rd_n(rd_n),
    .host_rdy(host_rdy), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_chan(mem_chan), .mem_wdata(mem_wdata),
    .mem_done(mem_done)
);

// File: tb/hostport_bridge_test.sv
module hostport_bridge_test;
    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 6;

    logic        clk = 0, rst = 1;
    logic        bus_mode = 0, cs_n = 1, rd_n = 1, wr_n = 1;
    logic [2:0]  addr = 0;
    logic [7:0]  din = 0, dout;
    logic        host_rdy, mem_req, mem_we, mem_done = 0;
    logic [9:0]  mem_addr;
    logic [5:0]  mem_chan;
    logic [19:0] mem_wdata, mem_rdata = 0;

    int errors = 0, checks = 0, req_count = 0, cnt = 0;
    logic [5:0] last_chan = 0;
    logic       last_we = 0;
    logic [19:0] mem [1024];
    bit done_run = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hostport_bridge uut (
        .clk(clk), .rst(rst), .bus_mode(bus_mode), .cs_n(cs_n), .rd_n(rd_n),
        .wr_n(wr_n), .addr(addr), .din(din), .dout(dout), .host_rdy(host_rdy),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_chan(mem_chan), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_done(mem_done)
    );

    // internal-side responder with fixed latency
    always @(posedge clk) begin
        mem_done <= 1'b0;
        if (mem_req && !mem_done) begin
            if (cnt == LAT - 1) begin
                cnt       <= 0;
                mem_done  <= 1'b1;
                req_count <= req_count + 1;
                last_chan <= mem_chan;
                last_we   <= mem_we;
                if (mem_we) mem[mem_addr] <= mem_wdata;
                else        mem_rdata     <= mem[mem_addr];
            end else cnt <= cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic access(input bit rd, input logic [2:0] a, input logic [7:0] d,
                          output logic [7:0] q, output int low, output bit held,
                          output bit tmo);
        @(negedge clk);
        addr = a; din = d; low = 0; held = 1; tmo = 1;
        if (!bus_mode) begin
            if (rd) rd_n = 0; else wr_n = 0;
            for (int i = 0; i < 40; i++) begin
                @(negedge clk);
                if (!host_rdy) begin tmo = 0; break; end
            end
            if (!tmo) begin
                while (!host_rdy && low < 300) begin low++; @(negedge clk); end
                if (low >= 300) tmo = 1;
            end
            q = dout; rd_n = 1; wr_n = 1;
            repeat (6) @(negedge clk);
        end else begin
            wr_n = rd ? 1'b1 : 1'b0; rd_n = 0;
            for (int i = 0; i < 300; i++) begin
                @(negedge clk);
                if (!host_rdy) begin tmo = 0; break; end
            end
            q = dout;
            for (int i = 0; i < 5; i++) begin
                @(negedge clk);
                if (host_rdy) held = 0;
            end
            rd_n = 1;
            tmo = 1'b1 & tmo;
            begin
                bit back = 0;
                for (int i = 0; i < 20; i++) begin
                    @(negedge clk);
                    if (host_rdy) begin back = 1; break; end
                end
                if (!back) tmo = 1;
            end
            wr_n = 1;
            repeat (2) @(negedge clk);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d, input string req);
        logic [7:0] q; int low; bit held, tmo;
        access(0, a, d, q, low, held, tmo);
        chk(!tmo, req, "write handshake completes", tmo, 0);
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] q, input string req);
        int low; bit held, tmo;
        access(1, a, 8'h00, q, low, held, tmo);
        chk(!tmo, req, "read handshake completes", tmo, 0);
    endtask

    task automatic t_reset();
        chk(host_rdy == 1, "R1", "host_rdy after reset", host_rdy, 1);
        chk(mem_req == 0, "R1", "mem_req after reset", mem_req, 0);
        chk(dout == 0, "R1", "dout after reset", dout, 0);
    endtask

    task automatic t_pair_write();
        logic [7:0] q; int low, n0; bit held, tmo;
        bus_mode = 0;
        n0 = req_count;
        wr(3'd7, 8'h0D, "R2"); wr(3'd6, 8'h5A, "R2");
        wr(3'd2, 8'hF7, "R5"); wr(3'd1, 8'h34, "R3");
        chk(req_count == n0, "R3", "no access from setup writes", req_count, n0);
        access(0, 3'd0, 8'h12, q, low, held, tmo);
        chk(!tmo && low >= LAT, "R8", "ready low through internal write", low, LAT);
        chk(req_count == n0 + 1, "R3", "one access from stage0 write", req_count, n0 + 1);
        chk(last_we == 1, "R3", "access is a write", last_we, 1);
        chk(mem[10'h15A] == 20'h73412, "R5", "written word, top nibble masked",
            mem[10'h15A], 20'h73412);
        chk(last_chan == 6'd3, "R2", "channel field", last_chan, 3);
    endtask

    task automatic t_order();
        bus_mode = 0;
        wr(3'd6, 8'h01, "R2"); wr(3'd7, 8'hFE, "R2");
        wr(3'd2, 8'h01, "R3"); wr(3'd1, 8'h00, "R3"); wr(3'd0, 8'h99, "R3");
        chk(mem[10'h201] == 20'h10099, "R2", "pointer written low-first",
            mem[10'h201], 20'h10099);
        chk(last_chan == 6'h3F, "R2", "channel all ones", last_chan, 6'h3F);
    endtask

    task automatic t_strobe_read();
        logic [7:0] q; int low, n0; bit held, tmo;
        bus_mode = 0;
        wr(3'd7, 8'h0D, "R2"); wr(3'd6, 8'h5A, "R2");
        bus_mode = 1;
        n0 = req_count;
        access(1, 3'd0, 8'h00, q, low, held, tmo);
        chk(!tmo, "R9", "acknowledge low then released", tmo, 0);
        chk(held, "R9", "acknowledge held while strobe low", held, 1);
        chk(q == 8'h12, "R4", "stage0 read low byte", q, 8'h12);
        chk(req_count == n0 + 1 && last_we == 0, "R4", "one internal read",
            req_count, n0 + 1);
        rd(3'd1, q, "R4");
        chk(q == 8'h34, "R4", "stage1 middle byte", q, 8'h34);
        rd(3'd2, q, "R4");
        chk(q == 8'h07, "R5", "stage2 upper nibble zero", q, 8'h07);
        chk(req_count == n0 + 1, "R4", "no access from stage1/2 reads", req_count, n0 + 1);
    endtask

    task automatic t_strobe_write();
        bus_mode = 1;
        wr(3'd2, 8'h03, "R9"); wr(3'd1, 8'hBE, "R9"); wr(3'd0, 8'hEF, "R9");
        chk(mem[10'h15A] == 20'h3BEEF, "R3", "write in data-strobe mode",
            mem[10'h15A], 20'h3BEEF);
    endtask

    task automatic t_readback();
        logic [7:0] q;
        bus_mode = 0;
        rd(3'd6, q, "R2");
        chk(q == 8'h5A, "R2", "pointer-low readback", q, 8'h5A);
        rd(3'd7, q, "R2");
        chk(q == 8'h0D, "R2", "pointer-control readback", q, 8'h0D);
        wr(3'd2, 8'hFA, "R5");
        rd(3'd2, q, "R5");
        chk(q == 8'h0A, "R5", "stage2 keeps low nibble", q, 8'h0A);
    endtask

    task automatic t_reserved();
        logic [7:0] q; int n0;
        bus_mode = 0;
        n0 = req_count;
        wr(3'd5, 8'hFF, "R6"); wr(3'd3, 8'hFF, "R6");
        rd(3'd5, q, "R6");
        chk(q == 8'h00, "R6", "reserved 5 reads zero", q, 0);
        rd(3'd4, q, "R6");
        chk(q == 8'h00, "R6", "reserved 4 reads zero", q, 0);
        rd(3'd6, q, "R6");
        chk(q == 8'h5A, "R6", "pointer-low untouched", q, 8'h5A);
        chk(req_count == n0, "R6", "no internal access", req_count, n0);
    endtask

    task automatic t_chain();
        int n0;
        bus_mode = 0;
        n0 = req_count;
        wr(3'd0, 8'h01, "R7"); wr(3'd0, 8'h02, "R7"); wr(3'd0, 8'h03, "R7");
        chk(req_count == n0 + 3, "R7", "three pulses, three accesses", req_count, n0 + 3);
        chk(mem[10'h15A][7:0] == 8'h03, "R7", "last pulse data", mem[10'h15A][7:0], 3);
    endtask

    task automatic t_deselected();
        logic [7:0] q; bit quiet = 1; int n0;
        bus_mode = 0;
        n0 = req_count;
        @(negedge clk);
        cs_n = 1; addr = 3'd6; din = 8'h77; wr_n = 0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (!host_rdy) quiet = 0;
        end
        wr_n = 1;
        repeat (6) @(negedge clk);
        chk(quiet, "R11", "no handshake while deselected", quiet, 1);
        cs_n = 0;
        repeat (4) @(negedge clk);
        rd(3'd6, q, "R11");
        chk(q == 8'h5A, "R11", "pointer-low unchanged", q, 8'h5A);
        chk(req_count == n0, "R11", "no internal access", req_count, n0);
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = '0;
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        cs_n = 0;
        repeat (4) @(negedge clk);
        t_pair_write();
        t_order();
        t_strobe_read();
        t_strobe_write();
        t_readback();
        t_reserved();
        t_chain();
        t_deselected();
        done_run = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done_run) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule